// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block produces the word address for a synchronous memory that serves four-beat bursts. A caller starts a burst by pulling either of two active-low address strobes at a rising clock edge while the chip-enable qualifier is high. The external start address is then captured as the first beat. Each later edge with both strobes high and the advance input low moves to the next beat. An edge with advance high suspends the burst and keeps the current address.

Only the lowest two address bits take part in the sequence; the upper bits come from the captured start address and never change during a burst. A select input chooses the order. In linear order the low bits count up modulo four from the start value. In interleaved order the low bits of beat k are the start value XOR k. The select is applied to the stored start value and beat count without a register, so a change of order remaps the current beat at once.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the stored start address and the beat count, so `word_addr` reads zero after that edge.
- R2: `strobe_proc_n` low with `chip_en` high at a rising edge loads `ext_addr`; after that edge `word_addr` equals the loaded value (beat 0).
- R3: `strobe_ctrl_n` low with `chip_en` high at a rising edge loads `ext_addr` in the same way as R2.
- R4: Either strobe low with `chip_en` low at a rising edge is a deselect: nothing is loaded, no advance takes place, and `word_addr` keeps its value.
- R5: With `order_sel` = 0 (linear), each advance edge (both strobes high, `adv_n` low) makes `word_addr[1:0]` the previous value plus one, modulo 4 (for example 01, 10, 11, 00).
- R6: With `order_sel` = 1 (interleaved), `word_addr[1:0]` on beat k equals the start low bits XOR k (for example 01, 00, 11, 10).
- R7: `order_sel` acts combinationally on the stored start value and beat count: changing it mid-burst changes `word_addr[1:0]` in the same cycle without moving the beat count.
- R8: With both strobes high and `adv_n` high at a rising edge, `word_addr` keeps its value.
- R9: A load (R2 or R3) takes priority over an advance in the same cycle; `word_addr` becomes `ext_addr`, not its successor.
- R10: Advancing past the fourth beat continues the same modulo-4 sequence; `word_addr[16:2]` never changes on an advance, even when the low bits wrap from 11 to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 17 | External start address |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| chip_en | input | 1 | Chip-enable qualifier for strobe loads, active high |
| word_addr | output | 17 | Current word address |

## Verification
The hardest case to reach is a wrap in linear order from a start of 11 with every upper address bit at one, where any carry out of the low field would be visible at once; the stimulus loads 0x1FFFF and then advances six times so the sequence wraps more than once. Load-versus-advance priority and the deselect case need strobe, advance and chip enable driven together in one cycle, so the directed part sets all three at once and a long pseudo-random phase mixes them freely against the cycle-by-cycle model. Order changes in the middle of a suspended burst are also driven, to show the remap without any step of the beat count.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } burst_act_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
   import burst_pkg::*;
(
   input  logic       strobe_proc_n,
   input  logic       strobe_ctrl_n,
   input  logic       adv_n,
   input  logic       chip_en,
   output burst_act_e act
);
   logic any_strobe;
   assign any_strobe = !strobe_proc_n || !strobe_ctrl_n;

   always_comb begin
      if (any_strobe) begin
         // a strobe without the chip enabled is a deselect
         act = chip_en ? ACT_LOAD : ACT_HOLD;
      end else if (!adv_n) begin
         act = ACT_STEP;
      end else begin
         act = ACT_HOLD;
      end
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_pkg::*;
#(
   parameter int SEQ_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  burst_act_e       act,
   output logic [SEQ_W-1:0] beat
);
   always_ff @(posedge clk) begin
      if (rst) begin
         beat <= '0;
      end else begin
         case (act)
            ACT_LOAD: beat <= '0;
            ACT_STEP: beat <= beat + 1'b1;
            default:  beat <= beat;
         endcase
      end
   end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
   import burst_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  burst_act_e        act,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] start_addr
);
   always_ff @(posedge clk) begin
      if (rst) begin
         start_addr <= '0;
      end else if (act == ACT_LOAD) begin
         start_addr <= ext_addr;
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int SEQ_W = 2
) (
   input  logic [SEQ_W-1:0] start_low,
   input  logic [SEQ_W-1:0] beat,
   input  logic             interleave,
   output logic [SEQ_W-1:0] low_out
);
   logic [SEQ_W-1:0] lin_low;
   logic [SEQ_W-1:0] xor_low;

   // linear: modular sum, carry out of the field dropped
   assign lin_low = start_low + beat;

   for (genvar i = 0; i < SEQ_W; i++) begin : g_xor_bit
      assign xor_low[i] = start_low[i] ^ beat[i];
   end

   assign low_out = interleave ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int SEQ_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              strobe_proc_n,
   input  logic              strobe_ctrl_n,
   input  logic              adv_n,
   input  logic              order_sel,
   input  logic              chip_en,
   output logic [ADDR_W-1:0] word_addr
);
   localparam int HI_W = ADDR_W - SEQ_W;

   if (SEQ_W < 1) begin : g_bad_seq
      $error("burst_addr_gen: SEQ_W must be at least 1");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed SEQ_W");
   end

   burst_act_e        act;
   logic [SEQ_W-1:0]  beat;
   logic [ADDR_W-1:0] start_addr;
   logic [SEQ_W-1:0]  low_bits;

   burst_cmd_decode u_dec (
      .strobe_proc_n (strobe_proc_n),
      .strobe_ctrl_n (strobe_ctrl_n),
      .adv_n         (adv_n),
      .chip_en       (chip_en),
      .act           (act)
   );

   burst_beat_ctr #(.SEQ_W(SEQ_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .act  (act),
      .beat (beat)
   );

   burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk        (clk),
      .rst        (rst),
      .act        (act),
      .ext_addr   (ext_addr),
      .start_addr (start_addr)
   );

   burst_order_map #(.SEQ_W(SEQ_W)) u_map (
      .start_low  (start_addr[SEQ_W-1:0]),
      .beat       (beat),
      .interleave (order_sel),
      .low_out    (low_bits)
   );

   assign word_addr = {start_addr[ADDR_W-1:SEQ_W], low_bits};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 17,
   parameter int SEQ_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              strobe_proc_n,
   input logic              strobe_ctrl_n,
   input logic              adv_n,
   input logic              order_sel,
   input logic              chip_en,
   input logic [ADDR_W-1:0] word_addr
);
   logic strobe_any;
   logic step_req;
   assign strobe_any = !strobe_proc_n || !strobe_ctrl_n;
   assign step_req   = !strobe_any && !adv_n;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> word_addr == '0);

   // R2 and R3: either strobe loads
   assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (strobe_any && chip_en) |=> word_addr == $past(ext_addr));

   assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
      (strobe_any && !chip_en) |=>
         (order_sel != $past(order_sel)) || $stable(word_addr));

   assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
      (step_req && !order_sel) |=>
         order_sel ||
         (word_addr[SEQ_W-1:0] == SEQ_W'($past(word_addr[SEQ_W-1:0]) + 1)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!strobe_any && adv_n) |=>
         (order_sel != $past(order_sel)) || $stable(word_addr));

   assert_load_priority_R9: assert property (@(posedge clk) disable iff (rst)
      (strobe_any && chip_en && !adv_n) |=> word_addr == $past(ext_addr));

   assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
      step_req |=> word_addr[ADDR_W-1:SEQ_W] == $past(word_addr[ADDR_W-1:SEQ_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .ext_addr      (ext_addr),
   .strobe_proc_n (strobe_proc_n),
   .strobe_ctrl_n (strobe_ctrl_n),
   .adv_n         (adv_n),
   .order_sel     (order_sel),
   .chip_en       (chip_en),
   .word_addr     (word_addr)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [16:0] ext_addr = '0;
   logic        sp_n = 1'b1;
   logic        sc_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        ord = 1'b0;
   logic        ce = 1'b1;
   logic [16:0] word_addr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_gen u0 (
      .clk           (clk),
      .rst           (rst),
      .ext_addr      (ext_addr),
      .strobe_proc_n (sp_n),
      .strobe_ctrl_n (sc_n),
      .adv_n         (adv_n),
      .order_sel     (ord),
      .chip_en       (ce),
      .word_addr     (word_addr)
   );

   // behavioural reference: stored start address and beat number
   logic [16:0] m_start = '0;
   int          m_beat = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_start <= '0;
         m_beat  <= 0;
      end else if (!sp_n || !sc_n) begin
         if (ce) begin
            m_start <= ext_addr;
            m_beat  <= 0;
         end
      end else if (!adv_n) begin
         m_beat <= (m_beat + 1) % 4;
      end
   end

   function automatic logic [16:0] model_addr();
      logic [1:0] k;
      logic [1:0] lo;
      k  = 2'(m_beat);
      lo = ord ? (m_start[1:0] ^ k) : 2'((int'(m_start[1:0]) + m_beat) % 4);
      return {m_start[16:2], lo};
   endfunction

   task automatic check(input string tag, input logic [16:0] exp);
      checks++;
      if (word_addr !== exp) begin
         errors++;
         $display("FAIL %s: word_addr=%05h expected=%05h at %0t", tag, word_addr, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, let a rising edge pass, compare
   task automatic cyc(input logic p, input logic c, input logic a, input logic o,
                      input logic e, input logic [16:0] addr, input string tag);
      sp_n = p; sc_n = c; adv_n = a; ord = o; ce = e; ext_addr = addr;
      @(posedge clk);
      @(negedge clk);
      check(tag, model_addr());
   endtask

   task automatic idle_check(input logic [16:0] exp, input string tag);
      check(tag, exp);
   endtask

   initial begin
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      idle_check(17'h0, "R1");
      rst = 1'b0;

      // R2 load through processor strobe, linear walk and wrap
      cyc(0, 1, 1, 0, 1, 17'h1ABC5, "R2");
      idle_check(17'h1ABC5, "R2");
      cyc(1, 1, 0, 0, 1, 17'h0, "R5");
      idle_check(17'h1ABC6, "R5");
      cyc(1, 1, 0, 0, 1, 17'h0, "R5");
      idle_check(17'h1ABC7, "R5");
      cyc(1, 1, 0, 0, 1, 17'h0, "R5");
      idle_check(17'h1ABC4, "R5");
      cyc(1, 1, 0, 0, 1, 17'h0, "R10");
      idle_check(17'h1ABC5, "R10");

      // R8 suspend
      cyc(1, 1, 1, 0, 1, 17'h12345, "R8");
      idle_check(17'h1ABC5, "R8");

      // R7: remap by order select with the beat count held (beat 0 here, advance once first)
      cyc(1, 1, 0, 0, 1, 17'h0, "R5");
      idle_check(17'h1ABC6, "R5");
      ord = 1'b1;
      #0.5;
      idle_check(17'h1ABC4, "R7");   // start 01 XOR beat 1 = 00
      ord = 1'b0;
      #0.5;
      idle_check(17'h1ABC6, "R7");

      // R3 load through controller strobe, interleaved order
      cyc(1, 0, 1, 1, 1, 17'h0F0F1, "R3");
      idle_check(17'h0F0F1, "R3");
      cyc(1, 1, 0, 1, 1, 17'h0, "R6");
      idle_check(17'h0F0F0, "R6");
      cyc(1, 1, 0, 1, 1, 17'h0, "R6");
      idle_check(17'h0F0F3, "R6");
      cyc(1, 1, 0, 1, 1, 17'h0, "R6");
      idle_check(17'h0F0F2, "R6");
      cyc(1, 1, 0, 1, 1, 17'h0, "R10");
      idle_check(17'h0F0F1, "R10");

      // R4 deselect: strobes low with chip disabled, advance also low
      cyc(1, 0, 0, 1, 0, 17'h15555, "R4");
      idle_check(17'h0F0F1, "R4");
      cyc(0, 1, 0, 1, 0, 17'h0AAAA, "R4");
      idle_check(17'h0F0F1, "R4");

      // R9 load beats advance
      cyc(0, 1, 0, 0, 1, 17'h00002, "R9");
      idle_check(17'h00002, "R9");
      cyc(1, 0, 0, 1, 1, 17'h10003, "R9");
      idle_check(17'h10003, "R9");

      // R10 no carry from an all-ones start in linear order
      cyc(0, 1, 1, 0, 1, 17'h1FFFF, "R2");
      for (int i = 0; i < 6; i++) begin
         cyc(1, 1, 0, 0, 1, 17'h0, "R10");
         checks++;
         if (word_addr[16:2] !== 15'h7FFF) begin
            errors++;
            $display("FAIL R10: upper=%04h expected=7fff", word_addr[16:2]);
         end
      end

      // mid-run reset
      cyc(1, 1, 0, 0, 1, 17'h0, "R5");
      rst = 1'b1;
      cyc(1, 1, 0, 0, 1, 17'h0, "R1");
      idle_check(17'h0, "R1");
      rst = 1'b0;

      // mixed pseudo-random traffic against the model
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[0] | r[1], r[2] | r[3], r[4], r[5], r[6] | r[7], r[24:8], "R2..R10 mix");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int n = 0; n < 20000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule